// File: doc/BRIEF.md
# Transition-Serviced Watchdog Timer

This block watches a keep-alive signal from a processor. Each time that signal changes level, in either direction, the timeout counter starts again from zero. If the signal holds one level for a whole timeout period, the block issues a one-cycle reset request to the reset generator. At the same moment it pulls an active-low fault output low. The fault output goes high again on the next level change, or as soon as the supply-low indication is present.

The counter advances only on cycles where the timebase tick input is high. Two periods are available, a long one and a short one, each set as a tick count by a parameter. After any reset, the first period is always the long one, whatever the select input says. A disable input stands in for an unconnected keep-alive signal. While it is high the counter stays at zero and no request is made. The keep-alive input is asynchronous and passes through a synchronizer before edges are detected.

Top module: `svc_watchdog`

## Requirements
- R1: Every rising and every falling level change on `wdi_i` restarts the count. A change driven before clock edge k clears the counter at edge k+2, after two synchronizer stages and one edge-detect stage. The next request then comes exactly one period later.
- R2: When the count reaches the active period, `timeout_req_o` goes high and `fault_n_o` goes low at the same clock edge. `fault_n_o` stays low until R6 releases it.
- R3: While `wd_off_i` is 1, the counter is held at zero and `timeout_req_o` stays 0. After `wd_off_i` returns to 0, counting restarts from zero.
- R4: `short_sel_i` = 1 selects SHORT_TICKS and 0 selects LONG_TICKS. Only cycles with `tick_i` = 1 count. If the selected period drops below the current count, the next tick ends the period.
- R5: Following `rst_ni` release or a one-cycle `rst_release_i` pulse, LONG_TICKS applies regardless of `short_sel_i` until the next level change on `wdi_i`.
- R6: `fault_n_o` returns to 1 at the clock edge that sees a level change of `wdi_i` (as timed in R1), or at the first clock edge while `supply_low_i` is 1.
- R7: Without service, a request repeats once every period.
- R8: While `supply_low_i` or `rst_active_i` is 1, the counter is held at zero and no request is made. Counting restarts from zero when both are 0.
- R9: `timeout_req_o` is a single-cycle pulse, and the counter restarts from zero after each request.
- R10: During and right after `rst_ni` low, `timeout_req_o` is 0 and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase enable; one count per high cycle |
| wdi_i | input | 1 | Asynchronous keep-alive level from the processor |
| wd_off_i | input | 1 | Watchdog disabled (input left unconnected) |
| short_sel_i | input | 1 | 1 = short period, 0 = long period |
| supply_low_i | input | 1 | Supply below threshold |
| rst_active_i | input | 1 | Reset generator is holding reset |
| rst_release_i | input | 1 | One-cycle pulse when the reset generator releases reset |
| timeout_req_o | output | 1 | One-cycle reset request on timeout |
| fault_n_o | output | 1 | Active-low watchdog fault indication |

## Verification
The bench builds the block with LONG_TICKS = 20 and SHORT_TICKS = 6. At these values, repeated long and short timeouts each fit into a few dozen cycles. They also make a short select that is overridden by the forced long period after a reset clearly distinguishable. The small counts also make it cheap to run hold windows (disable, supply low, reset active, tick gating) that are much longer than a period. Request times are predicted from the three-cycle path from the keep-alive input to the clear.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

    typedef enum logic {
        SEL_LONG  = 1'b0,
        SEL_SHORT = 1'b1
    } period_sel_e;

    typedef struct packed {
        logic fault_n;
        logic long_first;
    } wd_flags_t;

endpackage

// File: rtl/svc_wdog_sync.sv
module svc_wdog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = d_i;
        end else begin : g_chain
            always_comb ff_d = {ff_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= ff_d;
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/svc_wdog_edge.sv
module svc_wdog_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign edge_o = lvl_i ^ prev_q;
endmodule

// File: rtl/svc_wdog_count.sv
module svc_wdog_count #(
    parameter int LONG_TICKS  = 1600,
    parameter int SHORT_TICKS = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic tick_i,
    input  logic use_short_i,
    output logic hit_o,
    output logic fire_o
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CW-1:0] last_val;
    logic          hit;

    always_comb begin
        st_d     = st_q;
        last_val = use_short_i ? SHORT_LAST : LONG_LAST;
        hit      = 1'b0;
        st_d.fire = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= last_val) begin
                hit       = 1'b1;
                st_d.cnt  = '0;
                st_d.fire = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hit_o  = hit;
    assign fire_o = st_q.fire;

    // R1
    count_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (st_q.cnt == '0));

    // R4
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LONG_LAST);
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdog_pkg::*;
#(
    parameter int LONG_TICKS  = 1600,
    parameter int SHORT_TICKS = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic wdi_i,
    input  logic wd_off_i,
    input  logic short_sel_i,
    input  logic supply_low_i,
    input  logic rst_active_i,
    input  logic rst_release_i,
    output logic timeout_req_o,
    output logic fault_n_o
);
    logic      wdi_s, wd_edge, hit, fire, clear, use_short;
    wd_flags_t fl_d, fl_q;

    svc_wdog_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (wdi_i),
        .q_o   (wdi_s)
    );

    svc_wdog_edge i_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (wdi_s),
        .edge_o(wd_edge)
    );

    always_comb begin
        clear     = supply_low_i | rst_active_i | wd_off_i | wd_edge;
        use_short = (period_sel_e'(short_sel_i) == SEL_SHORT) && !fl_q.long_first;
    end

    svc_wdog_count #(
        .LONG_TICKS (LONG_TICKS),
        .SHORT_TICKS(SHORT_TICKS)
    ) i_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (clear),
        .tick_i     (tick_i),
        .use_short_i(use_short),
        .hit_o      (hit),
        .fire_o     (fire)
    );

    always_comb begin
        fl_d = fl_q;
        if (rst_release_i)  fl_d.long_first = 1'b1;
        else if (wd_edge)   fl_d.long_first = 1'b0;
        if (hit)                         fl_d.fault_n = 1'b0;
        if (wd_edge || supply_low_i)     fl_d.fault_n = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '{fault_n: 1'b1, long_first: 1'b1};
        else         fl_q <= fl_d;
    end

    assign timeout_req_o = fire;
    assign fault_n_o     = fl_q.fault_n;

    // R2
    req_fault_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_req_o |-> !fault_n_o);

    // R3
    off_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wd_off_i |=> !timeout_req_o);

    // R6
    supply_fault_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        supply_low_i |=> fault_n_o);

    // R8
    hold_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (supply_low_i || rst_active_i) |=> !timeout_req_o);

    // R9
    req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_req_o |=> !timeout_req_o);
endmodule

// File: tb/test_svc_watchdog.sv
module test_svc_watchdog;
    localparam int LP = 20;
    localparam int SP = 6;

    logic clk = 1'b0;
    logic rst_ni, tick, wdi, wd_off, short_sel, supply_low, rst_act, rst_rel;
    logic req, fault_n;

    always #5 clk = ~clk;

    svc_watchdog #(.LONG_TICKS(LP), .SHORT_TICKS(SP)) i_svc_watchdog (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .wdi_i        (wdi),
        .wd_off_i     (wd_off),
        .short_sel_i  (short_sel),
        .supply_low_i (supply_low),
        .rst_active_i (rst_act),
        .rst_release_i(rst_rel),
        .timeout_req_o(req),
        .fault_n_o    (fault_n)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0, n_fail = 0, n_pulse = 0;
    bit    mon_en = 1'b0;
    int    exp_at[$];
    string exp_tag[$];

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_pulse(int at, string tag);
        exp_at.push_back(at);
        exp_tag.push_back(tag);
    endtask

    task automatic wait_to(int at);
        while (cyc < at) @(negedge clk);
    endtask

    // monitor: pops expected pulses as the design produces them
    always @(negedge clk) begin
        if (mon_en) begin
            while (exp_at.size() > 0 && exp_at[0] < cyc) begin
                check(1'b0, exp_tag[0], "missing pulse at cycle", -1, exp_at[0]);
                void'(exp_at.pop_front());
                void'(exp_tag.pop_front());
            end
            if (req) begin
                n_pulse++;
                if (exp_at.size() > 0 && exp_at[0] == cyc) begin
                    check(fault_n == 1'b0, exp_tag[0], "fault_n at pulse", fault_n, 0);
                    void'(exp_at.pop_front());
                    void'(exp_tag.pop_front());
                end else begin
                    check(1'b0, "R9", "unexpected pulse at cycle", cyc, -1);
                end
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish, cycle", cyc, -1);
        summary();
        $finish;
    end

    initial begin
        int c, p0;
        rst_ni = 0; tick = 1; wdi = 0; wd_off = 0; short_sel = 1;
        supply_low = 0; rst_act = 0; rst_rel = 0;
        repeat (3) @(negedge clk);
        check(req == 1'b0, "R10", "req in reset", req, 0);
        check(fault_n == 1'b1, "R10", "fault_n in reset", fault_n, 1);
        mon_en = 1'b1;

        // R5: long period first despite short select; R7 repeats
        c = cyc; rst_ni = 1;
        expect_pulse(c + LP, "R5");
        expect_pulse(c + 2*LP, "R7");
        wait_to(c + 2*LP + 1);
        check(fault_n == 1'b0, "R2", "fault_n held low", fault_n, 0);

        // R6: edge releases fault; R4 short period now applies
        c = cyc; wdi = ~wdi;
        expect_pulse(c + 3 + SP, "R4");
        expect_pulse(c + 3 + 2*SP, "R7");
        wait_to(c + 3);
        check(fault_n == 1'b1, "R6", "fault_n after edge", fault_n, 1);
        wait_to(c + 3 + 2*SP + 1);

        // R1: service with both edge directions under long period
        short_sel = 0;
        p0 = n_pulse;
        for (int i = 0; i < 8; i++) begin
            c = cyc; wdi = ~wdi;
            wait_to(c + 10);
        end
        check(n_pulse == p0, "R1", "pulses while serviced", n_pulse, p0);
        c = cyc; wdi = ~wdi;
        expect_pulse(c + 3 + LP, "R1");
        wait_to(c + 3 + LP + 1);

        // R3: disabled watchdog
        wd_off = 1;
        p0 = n_pulse;
        repeat (60) @(negedge clk);
        check(n_pulse == p0, "R3", "pulses while disabled", n_pulse, p0);
        c = cyc; wd_off = 0;
        expect_pulse(c + LP, "R3");
        wait_to(c + LP + 1);

        // R8 / R6: supply low
        c = cyc; supply_low = 1; p0 = n_pulse;
        wait_to(c + 1);
        check(fault_n == 1'b1, "R6", "fault_n after supply low", fault_n, 1);
        wait_to(c + 50);
        check(n_pulse == p0, "R8", "pulses during supply low", n_pulse, p0);
        c = cyc; supply_low = 0;
        expect_pulse(c + LP, "R8");
        wait_to(c + LP + 1);

        // R8 / R5: reset generator hold and release pulse
        short_sel = 1;
        wdi = ~wdi;
        @(negedge clk);
        rst_act = 1; p0 = n_pulse;
        repeat (40) @(negedge clk);
        check(n_pulse == p0, "R8", "pulses while reset active", n_pulse, p0);
        c = cyc; rst_act = 0; rst_rel = 1;
        @(negedge clk);
        rst_rel = 0;
        expect_pulse(c + LP, "R5");
        expect_pulse(c + 2*LP, "R7");
        wait_to(c + 2*LP + 1);

        // R4: counting only on tick cycles
        c = cyc; wdi = ~wdi; tick = 0;
        wait_to(c + 30);
        tick = 1;
        expect_pulse(c + 30 + SP, "R4");
        wait_to(c + 30 + SP + 1);
        wdi = ~wdi;
        repeat (5) @(negedge clk);
        check(exp_at.size() == 0, "R9", "pending expected pulses", exp_at.size(), 0);
        mon_en = 1'b0;

        summary();
        $finish;
    end
endmodule